// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the host-facing register and interrupt front end of a two-channel serial controller. A host issues single-cycle byte reads and writes on a four-location window. Each location picks a channel and either that channel's control port or its data port. Each channel holds sixteen write registers and exposes sixteen read registers. Both sets are reached through an indirect pointer that is loaded by a control write and that falls back to zero after each register access.

The block keeps, per channel, receive and transmit interrupt pending flags and under-service flags. From these it keeps an interrupt vector byte and a pending summary byte, and it drives one combined interrupt request. Received bytes enter through a valid/ready push port. The ready signal is low whenever the target channel's receiver is disabled, the channel still holds an unread byte, or a host access is in the same cycle. A push with ready low is refused, and the source must hold it and retry. A one-cycle break pulse per channel sets a sticky break status.

Top module: `sdual_regif`

## Requirements
- R1: Address bit SEL_BIT selects control (0) or data (1). Bit SEL_BIT+1 selects the channel: 1 is channel A and 0 is channel B. Each channel's registers are separate.
- R2: A control write while the pointer is 0 loads the pointer with bits 2:0. If bits 5:3 equal 001, it adds 8, so 0x0C points at register 12.
- R3: A control write while the pointer is nonzero writes that register and returns the pointer to 0. Every control read returns the selected read register, returns the pointer to 0, and presents its data on bus_rdata in the cycle after the strobe.
- R4: After reset, status register 0 reads 0x44 and register 1 reads 0x07. The vector and the pending byte read 0x00. Break interrupts are enabled (write register 15 bit 7 resets to 1), and the receiver is disabled.
- R5: A command field (bits 5:3, pointer 0) of 101 clears the transmit interrupt of that channel. A value of 111 clears receive if receive is under service, or else transmit if transmit is under service.
- R6: A write to register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both. The writing channel's pointer is left unchanged unless that channel is itself reset. With bits 7:6 = 00, the value is stored.
- R7: The vector (channel B register 2) with register 9 bit 4 of the event's channel clear is: none 0x06, rx A 0x0C, rx B 0x04, tx A 0x08, tx B 0x00.
- R8: With register 9 bit 4 set, the vector codes are: none 0x60, rx A 0x30, rx B 0x20, tx A 0x10. Tx B stays 0x00.
- R9: Channel A register 3 reads the pending bits: tx B 0x02, rx B 0x04, tx A 0x10, rx A 0x20. Channel B register 3 and channel A register 2 read 0x00.
- R10: A receive interrupt takes the vector only when transmit is not under service, and the reverse also holds. Clearing one interrupt hands the vector to the other if that one is still pending.
- R11: irq is high when, for either channel, one of these holds: register 1 bit 1 is set and tx is pending; register 1 bits 4:3 are 01 or 10 and rx is pending; or register 15 bit 7 is set and break status (register 0 bit 7) is set. A mode of 11 raises no rx request.
- R12: A data write raises the transmit interrupt, and registers 0 and 1 keep tx-empty (bit 2) and all-sent (bit 0) set. A data read returns the held byte, clears rx-available (register 0 bit 0), and clears the receive interrupt.
- R13: rx_ready is high only when register 3 bit 0 of the channel on rx_chan is set, that channel holds no unread byte, and no host access is present. A refused push changes nothing.
- R14: Reading registers 12 and 13 returns the last values written to write registers 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host byte write strobe |
| bus_rd | input | 1 | Host byte read strobe (ignored when bus_wr is high) |
| bus_addr | input | SEL_BIT+2 | Host address; bit SEL_BIT control/data, bit SEL_BIT+1 channel |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after bus_rd |
| rx_valid | input | 1 | Receive push valid |
| rx_ready | output | 1 | Receive push accepted this cycle |
| rx_chan | input | 1 | Receive target channel (1 = A) |
| rx_data | input | 8 | Received byte |
| brk_evt | input | 2 | Break pulse per channel (bit 1 = A) |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data is sampled at the falling edge that follows the edge which took bus_rd, which is exactly one register stage after the strobe. A scoreboard queue pairs each issued read with its expected byte, so the comparison lands in that cycle. Interrupt state, the vector and rx_ready change at the rising edge that takes a write or push. irq and rx_ready are combinational from that state, so the bench checks them at a later falling edge, after the driving task has returned. Vector and pending values are always observed through later register reads, and each of those reads is itself one cycle after its strobe.

// File: rtl/sdual_pkg.sv
package sdual_pkg;
  localparam int NCH  = 2;
  localparam int CH_B = 0;
  localparam int CH_A = 1;
  localparam int REGS = 16;
  localparam int PW   = $clog2(REGS);

  localparam logic [2:0] CMD_HIGH    = 3'b001;
  localparam logic [2:0] CMD_CLR_TX  = 3'b101;
  localparam logic [2:0] CMD_CLR_TOP = 3'b111;

  localparam logic [PW-1:0] IDX_VEC   = PW'(2);
  localparam logic [PW-1:0] IDX_PEND  = PW'(3);
  localparam logic [PW-1:0] IDX_RESET = PW'(9);

  typedef enum logic [2:0] {
    EV_NONE, EV_SET_RX, EV_SET_TX, EV_CLR_RX, EV_CLR_TX, EV_CLR_TOP
  } iev_e;

  typedef enum logic [1:0] {VK_NONE, VK_RX, VK_TX} vkind_e;

  typedef struct packed {
    logic rxp;
    logic txp;
    logic rxs;
    logic txs;
  } iflag_t;

  function automatic logic [7:0] vec_code(vkind_e k, logic is_a, logic hi);
    case (k)
      VK_RX:   return is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
      VK_TX:   return is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
      default: return hi ? 8'h60 : 8'h06;
    endcase
  endfunction

  function automatic logic [7:0] wr_init(int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sdual_chan.sv
module sdual_chan
  import sdual_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          ctl_wr,
  input  logic          ctl_rd,
  input  logic          data_rd,
  input  logic          keep_ptr,
  input  logic [7:0]    wdata,
  input  logic          rx_load,
  input  logic [7:0]    rx_byte,
  input  logic          brk_evt,
  output logic [PW-1:0] ptr,
  output logic          rx_en,
  output logic          rx_avail,
  output logic          status_hi,
  output logic          tx_ie,
  output logic [1:0]    rx_mode,
  output logic          brk_en,
  output logic          brk_st,
  output logic [7:0]    rx_buf,
  output logic [7:0]    rr_loc
);
  logic [7:0]    wr_q [REGS];
  logic [PW-1:0] ptr_q;
  logic          avail_q, brk_q;
  logic [7:0]    buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) wr_q[i] <= wr_init(i);
      ptr_q <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < REGS; i++) wr_q[i] <= wr_init(i);
      ptr_q <= '0;
    end else if (ctl_wr) begin
      if (ptr_q == '0) begin
        ptr_q <= {(wdata[5:3] == CMD_HIGH), wdata[2:0]};
      end else if (!keep_ptr) begin
        wr_q[ptr_q] <= wdata;
        ptr_q       <= '0;
      end
    end else if (ctl_rd) begin
      ptr_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      brk_q   <= 1'b0;
      buf_q   <= '0;
    end else if (soft_rst) begin
      avail_q <= 1'b0;
      brk_q   <= 1'b0;
      buf_q   <= '0;
    end else begin
      if (rx_load) begin
        avail_q <= 1'b1;
        buf_q   <= rx_byte;
      end else if (data_rd) begin
        avail_q <= 1'b0;
      end
      if (brk_evt) brk_q <= 1'b1;
    end
  end

  always_comb begin
    case (ptr_q)
      PW'(0):  rr_loc = {brk_q, 1'b1, 3'b000, 1'b1, 1'b0, avail_q};
      PW'(1):  rr_loc = 8'h07;
      PW'(12): rr_loc = wr_q[12];
      PW'(13): rr_loc = wr_q[13];
      default: rr_loc = 8'h00;
    endcase
  end

  assign ptr       = ptr_q;
  assign rx_en     = wr_q[3][0];
  assign rx_avail  = avail_q;
  assign status_hi = wr_q[9][4];
  assign tx_ie     = wr_q[1][1];
  assign rx_mode   = wr_q[1][4:3];
  assign brk_en    = wr_q[15][7];
  assign brk_st    = brk_q;
  assign rx_buf    = buf_q;

  AST_PTR_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !ctl_wr) |=> (ptr_q == '0)); // R3

  AST_RX_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_q && !data_rd && !soft_rst) |=> $stable(buf_q)); // R13
endmodule

// File: rtl/sdual_intc.sv
module sdual_intc
  import sdual_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       soft_rst,
  input  iev_e                 ev,
  input  logic                 ev_ch,
  input  logic [NCH-1:0]       hi,
  input  logic [NCH-1:0]       tx_ie,
  input  logic [NCH-1:0][1:0]  rx_mode,
  input  logic [NCH-1:0]       brk_en,
  input  logic [NCH-1:0]       brk_st,
  output logic [7:0]           vec,
  output logic [7:0]           pend,
  output logic                 irq
);
  iflag_t [NCH-1:0] fl_q;
  logic [7:0]       vec_q;
  iflag_t           nf;
  logic [7:0]       nv;
  logic             crx, ctx;
  logic [NCH-1:0]   ch_req;

  always_comb begin
    nf  = fl_q[ev_ch];
    nv  = vec_q;
    crx = (ev == EV_CLR_RX) || (ev == EV_CLR_TOP && nf.rxs);
    ctx = (ev == EV_CLR_TX) || (ev == EV_CLR_TOP && !nf.rxs && nf.txs);
    if (ev == EV_SET_RX) begin
      nf.rxp = 1'b1;
      if (!nf.txs) begin nf.rxs = 1'b1; nv = vec_code(VK_RX, ev_ch, hi[ev_ch]); end
    end
    if (ev == EV_SET_TX) begin
      nf.txp = 1'b1;
      if (!nf.rxs) begin nf.txs = 1'b1; nv = vec_code(VK_TX, ev_ch, hi[ev_ch]); end
    end
    if (crx) begin
      nf.rxp = 1'b0;
      nf.rxs = 1'b0;
      nv     = vec_code(VK_NONE, ev_ch, hi[ev_ch]);
      if (nf.txp) begin nf.txs = 1'b1; nv = vec_code(VK_TX, ev_ch, hi[ev_ch]); end
    end
    if (ctx) begin
      nf.txp = 1'b0;
      nf.txs = 1'b0;
      nv     = vec_code(VK_NONE, ev_ch, hi[ev_ch]);
      if (nf.rxp) begin nf.rxs = 1'b1; nv = vec_code(VK_RX, ev_ch, hi[ev_ch]); end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= '0;
      vec_q <= '0;
    end else begin
      if (ev != EV_NONE) begin
        fl_q[ev_ch] <= nf;
        vec_q       <= nv;
      end
      for (int k = 0; k < NCH; k++)
        if (soft_rst[k]) fl_q[k] <= '0;
      if (soft_rst[CH_B]) vec_q <= '0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_req
    assign ch_req[g] = (tx_ie[g] && fl_q[g].txp) ||
                       ((rx_mode[g] == 2'b01 || rx_mode[g] == 2'b10) && fl_q[g].rxp) ||
                       (brk_en[g] && brk_st[g]);

    AST_SVC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_q[g].rxs && fl_q[g].txs)); // R10

    AST_SVC_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_q[g].rxs || fl_q[g].rxp) && (!fl_q[g].txs || fl_q[g].txp)); // R10

    AST_TX_PEND_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_SET_TX && ev_ch == g[0] && !soft_rst[g]) |=> fl_q[g].txp); // R12
  end

  assign irq  = |ch_req;
  assign vec  = vec_q;
  assign pend = {2'b00, fl_q[CH_A].rxp, fl_q[CH_A].txp, 1'b0,
                 fl_q[CH_B].rxp, fl_q[CH_B].txp, 1'b0};
endmodule

// File: rtl/sdual_regif.sv
module sdual_regif
  import sdual_pkg::*;
#(
  parameter int SEL_BIT = 0,
  localparam int AW     = SEL_BIT + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic          rx_chan,
  input  logic [7:0]    rx_data,
  input  logic [1:0]    brk_evt,
  output logic          irq
);
  logic                  is_data, sel_ch, rd_go;
  logic [NCH-1:0]        ctl_wr, ctl_rd, data_rd, keep_ptr, soft_rst, rx_load;
  logic [NCH-1:0][PW-1:0] ptr;
  logic [NCH-1:0]        rx_en, rx_avail, hi, tx_ie, brk_en, brk_st;
  logic [NCH-1:0][1:0]   rx_mode;
  logic [NCH-1:0][7:0]   rx_buf, rr_loc;
  logic [PW-1:0]         cur_ptr;
  logic                  rst_req, push_ok;
  iev_e                  ev;
  logic                  ev_ch;
  logic [7:0]            vec, pend, rd_mux;

  assign is_data = bus_addr[SEL_BIT];
  assign sel_ch  = bus_addr[SEL_BIT+1];
  assign rd_go   = bus_rd && !bus_wr;
  assign cur_ptr = ptr[sel_ch];
  assign rst_req = bus_wr && !is_data && (cur_ptr == IDX_RESET) && (bus_wdata[7:6] != 2'b00);
  assign rx_ready = rx_en[rx_chan] && !rx_avail[rx_chan] && !bus_wr && !bus_rd;
  assign push_ok  = rx_valid && rx_ready;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctl_wr[g]   = bus_wr && !is_data && (sel_ch == g[0]);
    assign ctl_rd[g]   = rd_go  && !is_data && (sel_ch == g[0]);
    assign data_rd[g]  = rd_go  &&  is_data && (sel_ch == g[0]);
    assign keep_ptr[g] = rst_req && (sel_ch == g[0]);
    assign soft_rst[g] = rst_req && bus_wdata[6 + g];
    assign rx_load[g]  = push_ok && (rx_chan == g[0]);

    sdual_chan u_chan (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst[g]),
      .ctl_wr(ctl_wr[g]), .ctl_rd(ctl_rd[g]), .data_rd(data_rd[g]),
      .keep_ptr(keep_ptr[g]), .wdata(bus_wdata),
      .rx_load(rx_load[g]), .rx_byte(rx_data), .brk_evt(brk_evt[g]),
      .ptr(ptr[g]), .rx_en(rx_en[g]), .rx_avail(rx_avail[g]),
      .status_hi(hi[g]), .tx_ie(tx_ie[g]), .rx_mode(rx_mode[g]),
      .brk_en(brk_en[g]), .brk_st(brk_st[g]),
      .rx_buf(rx_buf[g]), .rr_loc(rr_loc[g])
    );
  end

  always_comb begin
    ev    = EV_NONE;
    ev_ch = sel_ch;
    if (bus_wr && is_data) begin
      ev = EV_SET_TX;
    end else if (rd_go && is_data) begin
      ev = EV_CLR_RX;
    end else if (bus_wr && cur_ptr == '0) begin
      if (bus_wdata[5:3] == CMD_CLR_TX)       ev = EV_CLR_TX;
      else if (bus_wdata[5:3] == CMD_CLR_TOP) ev = EV_CLR_TOP;
    end else if (push_ok) begin
      ev    = EV_SET_RX;
      ev_ch = rx_chan;
    end
  end

  sdual_intc u_intc (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev(ev), .ev_ch(ev_ch),
    .hi(hi), .tx_ie(tx_ie), .rx_mode(rx_mode), .brk_en(brk_en), .brk_st(brk_st),
    .vec(vec), .pend(pend), .irq(irq)
  );

  always_comb begin
    if (is_data)                 rd_mux = rx_buf[sel_ch];
    else if (cur_ptr == IDX_VEC)  rd_mux = (sel_ch == 1'(CH_B)) ? vec  : 8'h00;
    else if (cur_ptr == IDX_PEND) rd_mux = (sel_ch == 1'(CH_A)) ? pend : 8'h00;
    else                         rd_mux = rr_loc[sel_ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_mux;
  end

  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> !rx_ready); // R13
endmodule

// File: tb/sim_sdual_regif.sv
module sim_sdual_regif;
  localparam logic CA = 1'b1, CB = 1'b0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, rx_data = '0;
  logic rx_valid = 0, rx_ready, rx_chan = 0, irq;
  logic [1:0] brk_evt = '0;
  int checks = 0, fails = 0;
  logic rd_q = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  sdual_regif u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_chan(rx_chan),
    .rx_data(rx_data), .brk_evt(brk_evt), .irq(irq)
  );

  // scoreboard monitor
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic bwr(input logic ch, input logic dat, input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1; bus_addr = {ch, dat}; bus_wdata = v;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic brd(input logic ch, input logic dat, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_rd = 1; bus_addr = {ch, dat};
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 0;
  endtask

  function automatic logic [7:0] pcode(input int idx);
    return (idx >= 8) ? (8'h08 | 8'(idx % 8)) : 8'(idx);
  endfunction

  task automatic wreg(input logic ch, input int idx, input logic [7:0] v);
    bwr(ch, 0, pcode(idx));
    bwr(ch, 0, v);
  endtask

  task automatic rreg(input logic ch, input int idx, input logic [7:0] e, input string t);
    if (idx != 0) bwr(ch, 0, pcode(idx));
    brd(ch, 0, e, t);
  endtask

  task automatic push(input logic ch, input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_chan = ch; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    chk(irq, e, t);
  endtask

  task automatic chk_ready(input logic ch, input logic e, input string t);
    @(negedge clk);
    rx_chan = ch;
    #1 chk(rx_ready, e, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // reset values
    rreg(CA, 0, 8'h44, "R4 RR0 reset");
    rreg(CA, 1, 8'h07, "R4 RR1 reset");
    rreg(CB, 2, 8'h00, "R4 vector reset");
    rreg(CA, 3, 8'h00, "R4 pending reset");
    rreg(CB, 12, 8'h00, "R14 RR12 reset");
    chk_irq(0, "R4 irq reset");
    chk_ready(CA, 0, "R13 rx disabled A");
    chk_ready(CB, 0, "R13 rx disabled B");

    // break raises irq through reset-enabled break interrupt, channel reset clears
    @(negedge clk); brk_evt = 2'b10; @(negedge clk); brk_evt = 2'b00;
    rreg(CA, 0, 8'hC4, "R11 break status");
    chk_irq(1, "R11 break irq");
    wreg(CA, 9, 8'h80);
    chk_irq(0, "R6 reset A clears break");
    rreg(CA, 0, 8'h44, "R6 RR0 after reset A");

    // receive path
    wreg(CA, 3, 8'h01);
    wreg(CA, 1, 8'h10);
    chk_ready(CA, 1, "R13 ready when enabled");
    chk_ready(CB, 0, "R1 channel B still disabled");
    push(CA, 8'h5A);
    chk_ready(CA, 0, "R13 not ready while byte held");
    rreg(CA, 0, 8'h45, "R12 rx available");
    rreg(CB, 2, 8'h0C, "R7 rx A vector");
    rreg(CA, 3, 8'h20, "R9 rx A pending");
    rreg(CB, 3, 8'h00, "R9 RR3 on B");
    rreg(CA, 2, 8'h00, "R9 RR2 on A");
    chk_irq(1, "R11 rx irq");
    push(CA, 8'hEE);
    brd(CA, 1, 8'h5A, "R13 refused push kept byte");
    rreg(CA, 0, 8'h44, "R12 rx available cleared");
    rreg(CB, 2, 8'h06, "R7 none vector");
    chk_irq(0, "R12 rx irq cleared");

    // transmit on B
    wreg(CB, 1, 8'h02);
    bwr(CB, 1, 8'h33);
    rreg(CA, 3, 8'h02, "R9 tx B pending");
    rreg(CB, 2, 8'h00, "R7 tx B vector");
    rreg(CB, 1, 8'h07, "R12 all sent");
    chk_irq(1, "R11 tx irq");
    bwr(CB, 0, 8'h28);
    rreg(CB, 2, 8'h06, "R5 clear tx vector");
    rreg(CA, 3, 8'h00, "R5 clear tx pending");
    chk_irq(0, "R5 clear tx irq");

    // under-service: tx first, rx waits
    do_reset();
    wreg(CA, 3, 8'h01);
    wreg(CA, 1, 8'h12);
    bwr(CA, 1, 8'h11);
    rreg(CB, 2, 8'h08, "R7 tx A vector");
    push(CA, 8'h77);
    rreg(CB, 2, 8'h08, "R10 rx blocked by tx service");
    rreg(CA, 3, 8'h30, "R9 both A pending");
    bwr(CA, 0, 8'h38);
    rreg(CB, 2, 8'h0C, "R10 rx takes vector");
    rreg(CA, 3, 8'h20, "R5 highest cleared tx");
    chk_irq(1, "R11 rx still pending");
    bwr(CA, 0, 8'h38);
    rreg(CB, 2, 8'h06, "R5 highest cleared rx");
    rreg(CA, 3, 8'h00, "R5 nothing pending");
    chk_irq(0, "R11 idle");
    brd(CA, 1, 8'h77, "R12 data read");

    // under-service: rx first, tx waits
    do_reset();
    wreg(CA, 3, 8'h01);
    wreg(CA, 1, 8'h12);
    push(CA, 8'h21);
    bwr(CA, 1, 8'h00);
    rreg(CB, 2, 8'h0C, "R10 tx blocked by rx service");
    brd(CA, 1, 8'h21, "R12 data read returns byte");
    rreg(CB, 2, 8'h08, "R10 tx re-raised");
    rreg(CA, 3, 8'h10, "R10 tx A pending only");
    bwr(CA, 0, 8'h28);
    rreg(CB, 2, 8'h06, "R5 clear tx");

    // status high
    do_reset();
    wreg(CB, 9, 8'h10);
    wreg(CB, 3, 8'h01);
    push(CB, 8'h42);
    rreg(CB, 2, 8'h20, "R8 rx B high");
    brd(CB, 1, 8'h42, "R12 data read B");
    rreg(CB, 2, 8'h60, "R8 none high");
    wreg(CA, 9, 8'h10);
    bwr(CA, 1, 8'h55);
    rreg(CB, 2, 8'h10, "R8 tx A high");
    wreg(CA, 3, 8'h01);
    push(CA, 8'h01);
    bwr(CA, 0, 8'h28);
    rreg(CB, 2, 8'h30, "R8 rx A high");
    bwr(CB, 1, 8'h00);
    rreg(CB, 2, 8'h00, "R8 tx B high");

    // pointer behaviour
    do_reset();
    bwr(CB, 0, 8'h0C);
    bwr(CB, 0, 8'h34);
    brd(CB, 0, 8'h44, "R3 pointer back to zero after write");
    rreg(CB, 12, 8'h34, "R2 point high reaches 12");
    wreg(CB, 13, 8'hA5);
    rreg(CB, 13, 8'hA5, "R14 RR13 mirror");
    rreg(CA, 12, 8'h00, "R1 channels separate");
    bwr(CB, 0, 8'h01);
    brd(CB, 0, 8'h07, "R3 read selected register");
    brd(CB, 0, 8'h44, "R3 pointer back to zero after read");

    // WR9 reset of the other channel keeps the pointer
    do_reset();
    wreg(CA, 3, 8'h01);
    wreg(CB, 1, 8'h02);
    bwr(CB, 1, 8'h00);
    chk_irq(1, "R11 tx B irq");
    bwr(CA, 0, 8'h09);
    bwr(CA, 0, 8'h40);
    chk_irq(0, "R6 reset B clears irq");
    brd(CA, 0, 8'h00, "R6 A pointer kept at 9");
    brd(CA, 0, 8'h44, "R6 A pointer cleared by read");
    chk_ready(CA, 1, "R6 A untouched by B reset");
    bwr(CA, 0, 8'h09);
    bwr(CA, 0, 8'hC0);
    chk_ready(CA, 0, "R6 reset both clears A");
    brd(CA, 0, 8'h44, "R6 pointer zero after own reset");

    // rx interrupt mode 11 gives no request
    do_reset();
    wreg(CA, 3, 8'h01);
    wreg(CA, 1, 8'h18);
    push(CA, 8'h10);
    chk_irq(0, "R11 mode 11 no irq");
    rreg(CA, 3, 8'h20, "R11 rx pending in mode 11");
    wreg(CA, 1, 8'h08);
    chk_irq(1, "R11 mode 01 irq");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule